// File: doc/BRIEF.md
# Byte-Wide Memory Configuration Streamer

This block reads configuration data from an external byte-wide memory and turns it into a continuous serial bit stream. It acts as a bus master. It drives an address bus and a read clock. On each rising edge of the read clock it latches the byte on the memory data bus. It then shifts that byte out least significant bit first, one bit per serial-clock period. The stream goes to two places: a local sink and a daisy-chain output for downstream devices. Both carry the same bit, and that bit changes only on the falling edge of the serial clock.

The read clock and the serial clock are both divided down from the system clock. They are locked at a fixed 1:8 ratio, so one byte is consumed per read-clock period. A start pulse latches the total byte count, clears the address and the shifter, and enables the clocks. The first read-clock period is a priming slot that fetches byte 0. From then on, each byte is fetched while the previous byte is still shifting, so the stream has no gaps. After the programmed number of bytes has been shifted out, both clocks stop, the address holds and a done flag stays high until the next start.

A bit-valid strobe accompanies every serial bit. A consumer can use it to frame the stream into bytes.

Top module: `cfg_byte_streamer`

## Requirements
- R1: While reset is high, and in the cycle after it, the address is 0 and done, read clock, serial clock and bit-valid are all low.
- R2: After a start, the first read-clock rising edge presents address 0. The address advances by exactly one when each read-clock high phase ends, so read-clock rising edge k (counting from 0) presents address k.
- R3: The byte sampled at read-clock rising edge k is the k-th byte of the stream. There is exactly one read-clock rising edge per byte in the programmed count.
- R4: Each byte leaves the serial outputs starting with bit 0 and ending with bit 7.
- R5: Consecutive read-clock rising edges are exactly 8 serial-clock periods apart (8*BIT_DIV system clocks).
- R6: While bit-valid stays high, the serial data changes only in the cycle where the serial clock falls. The local and daisy-chain outputs always carry the same value.
- R7: While bit-valid is high, consecutive serial-clock rising edges are exactly one serial-clock period (BIT_DIV system clocks) apart. Bit-valid covers exactly 8 times the byte count of serial-clock rising edges.
- R8: Once the last byte has been shifted out, done is high. The serial and read clocks stay low, bit-valid stays low and the address holds at the byte count until the next start.
- R9: A start with a byte count of 0 raises done one cycle later. It produces no read-clock edge and leaves the address at 0.
- R10: A start that arrives in the middle of a transfer abandons that transfer. The address returns to 0 and the new count is streamed in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| mem_data | input | 8 | Byte returned by the memory for the current address |
| byte_count | input | CNT_W | Number of bytes to stream, latched at start |
| mem_addr | output | ADDR_W | Memory address, 18 bits by default |
| rclk | output | 1 | Read clock; memory data is sampled on its rising edge |
| sclk | output | 1 | Serial clock, 8 times the read-clock frequency |
| ser_local | output | 1 | Serial data to the local sink |
| ser_chain | output | 1 | Serial data to the daisy chain |
| bit_valid | output | 1 | High while the serial outputs carry a stream bit |
| done | output | 1 | Transfer finished; held until the next start |

## Verification
A wrong phase or bit counter shows up within one serial period. It moves the data edge away from the serial-clock fall, or stretches the spacing between serial or read-clock edges. A faulty address counter or capture point shows at the next read-clock rising edge as an address that does not match the byte index. It also shows eight serial periods later as a rebuilt byte that differs from the memory model. Faults in the byte-count or termination logic appear only when the transfer ends, as a wrong number of bytes, a wrong final address, or clocks that keep running after done.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } stream_state_t;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen
  import cfg_stream_pkg::*;
#(
  parameter int BIT_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic cap_en,
  output logic tick,
  output logic byte_end,
  output logic cap_strobe,
  output logic sclk,
  output logic rclk
);
  localparam int PH_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
  localparam int HALF = BIT_DIV / 2;
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [BIT_IDX_W-1:0] CAP_BIT  = BIT_IDX_W'(BYTE_W / 2 - 1);

  logic [PH_W-1:0]      ph, ph_nxt;
  logic [BIT_IDX_W-1:0] bit_idx, bit_nxt;

  assign tick       = run && (ph == PH_W'(BIT_DIV - 1));
  assign byte_end   = tick && (bit_idx == LAST_BIT);
  assign cap_strobe = tick && (bit_idx == CAP_BIT) && cap_en;

  always_comb begin
    if (clear || !run) begin
      ph_nxt  = '0;
      bit_nxt = '0;
    end else if (tick) begin
      ph_nxt  = '0;
      bit_nxt = bit_idx + 1'b1;
    end else begin
      ph_nxt  = ph + 1'b1;
      bit_nxt = bit_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      bit_idx <= '0;
      sclk    <= 1'b0;
      rclk    <= 1'b0;
    end else begin
      ph      <= ph_nxt;
      bit_idx <= bit_nxt;
      sclk    <= run && !clear && (ph_nxt >= PH_W'(HALF));
      if (clear || !run)
        rclk <= 1'b0;
      else if (cap_strobe)
        rclk <= 1'b1;
      else if (byte_end)
        rclk <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      addr <= '0;
    else if (step)
      addr <= addr + 1'b1;
  end
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
  import cfg_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic              load,
  input  logic              advance,
  input  logic [BYTE_W-1:0] din,
  output logic              sd_local,
  output logic              sd_chain
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold_q   <= '0;
      sh_q     <= '0;
      sd_local <= 1'b0;
      sd_chain <= 1'b0;
    end else begin
      if (capture)
        hold_q <= din;
      if (load) begin
        sh_q     <= hold_q;
        sd_local <= hold_q[0];
        sd_chain <= hold_q[0];
      end else if (advance) begin
        sh_q     <= sh_q >> 1;
        sd_local <= sh_q[1];
        sd_chain <= sh_q[1];
      end
    end
  end
endmodule

// File: rtl/cfg_byte_streamer.sv
module cfg_byte_streamer
  import cfg_stream_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int CNT_W   = 18,
  parameter int BIT_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        mem_data,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rclk,
  output logic              sclk,
  output logic              ser_local,
  output logic              ser_chain,
  output logic              bit_valid,
  output logic              done
);
  stream_state_t    state;
  logic [CNT_W-1:0] cnt_q, loaded_q, sent_q;
  logic             run, cap_en, tick, byte_end, cap_strobe;
  logic             last_byte, load, advance, finish;

  assign run       = (state == ST_PRIME) || (state == ST_SHIFT);
  assign cap_en    = loaded_q < cnt_q;
  assign last_byte = (sent_q + CNT_W'(1)) == cnt_q;
  assign load      = byte_end && ((state == ST_PRIME) || ((state == ST_SHIFT) && !last_byte));
  assign advance   = tick && (state == ST_SHIFT) && !byte_end;
  assign finish    = byte_end && (state == ST_SHIFT) && last_byte;

  cfg_clk_gen #(.BIT_DIV(BIT_DIV)) clk_gen_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .run       (run),
    .cap_en    (cap_en),
    .tick      (tick),
    .byte_end  (byte_end),
    .cap_strobe(cap_strobe),
    .sclk      (sclk),
    .rclk      (rclk)
  );

  cfg_addr_gen #(.ADDR_W(ADDR_W)) addr_gen_i (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .step (rclk && byte_end),
    .addr (mem_addr)
  );

  cfg_serializer ser_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (start || finish),
    .capture (cap_strobe),
    .load    (load),
    .advance (advance),
    .din     (mem_data),
    .sd_local(ser_local),
    .sd_chain(ser_chain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      loaded_q  <= '0;
      sent_q    <= '0;
      done      <= 1'b0;
      bit_valid <= 1'b0;
    end else if (start) begin
      cnt_q     <= byte_count;
      loaded_q  <= '0;
      sent_q    <= '0;
      bit_valid <= 1'b0;
      if (byte_count == '0) begin
        state <= ST_DONE;
        done  <= 1'b1;
      end else begin
        state <= ST_PRIME;
        done  <= 1'b0;
      end
    end else begin
      if (cap_strobe)
        loaded_q <= loaded_q + 1'b1;
      case (state)
        ST_PRIME: if (byte_end) begin
          state     <= ST_SHIFT;
          bit_valid <= 1'b1;
        end
        ST_SHIFT: if (byte_end) begin
          sent_q <= sent_q + 1'b1;
          if (last_byte) begin
            state     <= ST_DONE;
            done      <= 1'b1;
            bit_valid <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_byte_streamer_chk.sv
module cfg_byte_streamer_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  byte_count,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rclk,
  input logic              sclk,
  input logic              ser_local,
  input logic              ser_chain,
  input logic              bit_valid,
  input logic              done
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !done && !rclk && !sclk && !bit_valid)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(rclk) && !$past(start)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2

  AST_DATA_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && $past(bit_valid) && (ser_local != $past(ser_local))) |-> $fell(sclk)); // R6

  AST_CHAIN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (ser_chain == ser_local)); // R6

  AST_CLOCKS_STOPPED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && !rclk && !bit_valid)); // R8

  AST_ADDR_HOLD_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(mem_addr)); // R8

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (start && byte_count == '0) |=> (done && !rclk && mem_addr == '0)); // R9
endmodule

bind cfg_byte_streamer cfg_byte_streamer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .byte_count(byte_count),
  .mem_addr  (mem_addr),
  .rclk      (rclk),
  .sclk      (sclk),
  .ser_local (ser_local),
  .ser_chain (ser_chain),
  .bit_valid (bit_valid),
  .done      (done)
);

// File: tb/cfg_byte_streamer_tb_top.sv
`timescale 1ns/1ps
module cfg_byte_streamer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 18;
  localparam int CNT_W   = 18;
  localparam int BIT_DIV = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [7:0]        mem_data;
  logic [ADDR_W-1:0] mem_addr;
  logic              rclk, sclk, ser_local, ser_chain, bit_valid, done;
  logic [7:0]        seed = 8'h00;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input int a, input logic [7:0] s);
    return 8'((a * 29) ^ (a >> 3)) ^ s;
  endfunction

  assign mem_data = mem_byte(int'(mem_addr), seed);

  cfg_byte_streamer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BIT_DIV(BIT_DIV)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mem_data(mem_data), .byte_count(byte_count),
    .mem_addr(mem_addr), .rclk(rclk), .sclk(sclk), .ser_local(ser_local),
    .ser_chain(ser_chain), .bit_valid(bit_valid), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Port monitor: rebuilds bytes and checks edge timing
  int   cyc = 0, run_bits = 0, run_bytes = 0, rclk_n = 0;
  int   last_rclk = 0, last_sclk = 0;
  logic p_sclk = 0, p_rclk = 0, p_sd = 0, p_vld = 0;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    if (rst || start) begin
      run_bits = 0; run_bytes = 0; rclk_n = 0; acc = '0;
    end else begin
      if (rclk && !p_rclk) begin
        chk(int'(mem_addr) == rclk_n, "R2 address at read edge", int'(mem_addr), rclk_n);
        if (rclk_n > 0)
          chk(cyc - last_rclk == 8*BIT_DIV, "R5 read-clock spacing", cyc - last_rclk, 8*BIT_DIV);
        last_rclk = cyc;
        rclk_n++;
      end
      if (sclk && !p_sclk && bit_valid) begin
        chk(ser_chain == ser_local, "R6 chain equals local", ser_chain, ser_local);
        if (run_bits > 0)
          chk(cyc - last_sclk == BIT_DIV, "R7 bit spacing", cyc - last_sclk, BIT_DIV);
        last_sclk = cyc;
        acc = {ser_local, acc[7:1]};
        run_bits++;
        if (run_bits % 8 == 0) begin
          chk(acc == mem_byte(run_bytes, seed), "R4 R3 rebuilt byte", acc, mem_byte(run_bytes, seed));
          run_bytes++;
        end
      end
      if (bit_valid && p_vld && ser_local != p_sd)
        chk(p_sclk && !sclk, "R6 data change on serial fall", {p_sclk, sclk}, 2);
    end
    p_sclk = sclk; p_rclk = rclk; p_sd = ser_local; p_vld = bit_valid;
    cyc++;
  end

  task automatic pulse_start(input int n, input logic [7:0] s);
    @(posedge clk); #1;
    seed = s; byte_count = CNT_W'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string tag);
    int k = 0;
    while (!done && k < limit) begin
      @(posedge clk); k++;
    end
    @(negedge clk);
    chk(done, tag, done, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(mem_addr == 0, "R1 reset address", int'(mem_addr), 0);
    chk({done, rclk, sclk, bit_valid} == 4'b0, "R1 reset controls", {done, rclk, sclk, bit_valid}, 0);
  endtask

  task automatic t_stream(input int n, input logic [7:0] s);
    logic [ADDR_W-1:0] a0;
    bit quiet = 1;
    pulse_start(n, s);
    wait_done(n*8*BIT_DIV + 64, "R8 done after stream");
    chk(run_bytes == n, "R7 byte total", run_bytes, n);
    chk(run_bits == 8*n, "R7 bit total", run_bits, 8*n);
    chk(rclk_n == n, "R3 read edges per byte", rclk_n, n);
    chk(int'(mem_addr) == n, "R8 final address", int'(mem_addr), n);
    a0 = mem_addr;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || rclk || bit_valid || !done) quiet = 0;
    end
    chk(quiet, "R8 clocks stopped while done", quiet, 1);
    chk(mem_addr == a0, "R8 address held", int'(mem_addr), int'(a0));
  endtask

  task automatic t_zero;
    pulse_start(0, 8'h5A);
    @(negedge clk);
    chk(done, "R9 done at once", done, 1);
    repeat (30) @(negedge clk);
    chk(rclk_n == 0, "R9 no read edges", rclk_n, 0);
    chk(mem_addr == 0, "R9 address untouched", int'(mem_addr), 0);
  endtask

  task automatic t_restart;
    pulse_start(6, 8'h33);
    repeat (45) @(posedge clk);
    pulse_start(3, 8'hC4);
    @(negedge clk);
    chk(mem_addr == 0 && !done, "R10 restart clears address", int'(mem_addr), 0);
    wait_done(3*8*BIT_DIV + 64, "R10 done after restart");
    chk(run_bytes == 3, "R10 new count streamed", run_bytes, 3);
    chk(int'(mem_addr) == 3, "R10 final address", int'(mem_addr), 3);
  endtask

  initial begin
    t_reset();
    t_stream(5, 8'h00);
    t_stream(1, 8'hA5);
    t_zero();
    t_restart();
    t_stream(9, 8'h6E);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule